// File: doc/BRIEF.md
# Short-Term Result Queue with Immediate Builder

This block holds the eight most recent instruction results of a 16-bit-instruction, 64-bit processor, together with the continuation flag that marks the previous instruction as a constant prefix. Each retiring instruction pushes its 64-bit value into the newest slot, and every older value moves one slot deeper. The oldest value falls off the end.

The block computes the value it pushes for two instruction classes on its own. A constant prefix contributes 13 bits. An immediate instruction contributes 11 bits. Either one extends the newest queued value by shifting it when the flag is set, so chains of prefixes build wide constants. For every other instruction the block takes the result supplied by the execution units.

It also produces the modified first operand. A 3-bit selector picks it, and the flag changes what each selector value means. A PC-relative load is not served here: the block raises a flag that asks the memory path to supply the value. The bitmask-immediate decode of the newest slot arrives on an input.

Top module: `result_queue_core`

## Requirements
- R1: After a synchronous reset, all eight slots are zero and the continuation flag is clear.
- R2: When `retire_i` is high, slot k takes the old value of slot k-1 for k = 1..7, and slot 0 takes the pushed value. For an instruction that is neither a prefix nor an immediate, the pushed value is `result_i`.
- R3: When `retire_i` is low, all slots and the flag hold, whatever `instr_i` and `result_i` carry.
- R4: A prefix instruction has `instr_i[15:13]` = 3'b110. It pushes `instr_i[12:0]` zero-extended, ORed with (old slot 0 << 13) when the flag was set.
- R5: A retired prefix sets the flag. Any other retired instruction clears it.
- R6: An immediate instruction has `instr_i[15:11]` = 5'b11110. It pushes `instr_i[10:0]` zero-extended, ORed with (slot 0 << 11) when the flag was set.
- R7: With the flag clear, `fr_o` depends on the selector as follows. Values 0..4 give the constants 0..4. Value 5 gives slot0 & 1. Value 6 gives slot0 + 1. Value 7 gives ~slot0.
- R8: With the flag set, `fr_o` depends on the selector as follows. Value 0 gives `mask_imm_i`. Values 1, 2 and 3 give slot0 shifted left by 8, 16 and 24. Value 7 gives ~slot0.
- R9: With the flag set, selector 4 gives `here_i` + even(slot0). Here even(x) is x when x[0] = 0 and ~x otherwise.
- R10: With the flag set, selector 6 gives the counter that slot0[1:0] picks. The codes are 0 for cycles, 1 for retired instructions, 2 for nanoseconds and 3 for the random value.
- R11: `fr_mem_o` is high exactly when the flag is set and the selector is 5. In that case `fr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | An instruction retires this cycle |
| instr_i | input | 16 | Retiring instruction word |
| result_i | input | 64 | Result from execution for other instructions |
| here_i | input | 64 | Address of the current instruction |
| mask_imm_i | input | 64 | Bitmask-immediate decode of slot 0 |
| perf_cyc_i | input | 64 | Cycle counter |
| perf_ret_i | input | 64 | Retired-instruction counter |
| perf_ns_i | input | 64 | Nanosecond counter |
| perf_rnd_i | input | 64 | Random value |
| fr_sel_i | input | 3 | Unary operand selector |
| sq_o | output | 512 | Slots, slot k at bits [64k+63:64k] |
| q_o | output | 1 | Continuation flag |
| fr_o | output | 64 | Modified first operand |
| fr_mem_o | output | 1 | Operand must come from memory |

## Verification
The bench builds chains of prefixes and checks the flag handoff. A design that used the new slot 0 instead of the old one, or that failed to clear the flag after an immediate, would build wrong wide constants. It checks odd and even slot values for the even() mapping; an inverted test there would flip the sign of PC-relative offsets. It walks slot0[1:0] through all four counter codes and holds the queue with junk on the instruction inputs. It also checks that the shift moves every slot, so an off-by-one in the generate chain would show as a duplicated or lost entry.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int INSTR_W   = 16;
  localparam int CONT_BITS = 13;
  localparam int IMM_BITS  = 11;
  localparam logic [2:0] CONT_TAG = 3'b110;
  localparam logic [4:0] IMM_TAG  = 5'b11110;

  typedef enum logic [1:0] {
    PUSH_EXEC,
    PUSH_CONT,
    PUSH_IMM
  } push_kind_e;

  function automatic push_kind_e classify(input logic [INSTR_W-1:0] w);
    if (w[INSTR_W-1 -: 3] == CONT_TAG)     return PUSH_CONT;
    else if (w[INSTR_W-1 -: 5] == IMM_TAG) return PUSH_IMM;
    else                                   return PUSH_EXEC;
  endfunction
endpackage

// File: rtl/rq_push_mux.sv
module rq_push_mux
  import rq_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  s0_i,
  input  logic               q_i,
  input  logic [DATA_W-1:0]  result_i,
  output logic [DATA_W-1:0]  push_o,
  output logic               is_cont_o
);
  push_kind_e kind;
  logic [DATA_W-1:0] cont_val, imm_val;

  always_comb begin
    kind      = classify(instr_i);
    cont_val  = {{(DATA_W-CONT_BITS){1'b0}}, instr_i[CONT_BITS-1:0]};
    imm_val   = {{(DATA_W-IMM_BITS){1'b0}}, instr_i[IMM_BITS-1:0]};
    if (q_i) begin
      cont_val = cont_val | (s0_i << CONT_BITS);
      imm_val  = imm_val  | (s0_i << IMM_BITS);
    end
    unique case (kind)
      PUSH_CONT: push_o = cont_val;
      PUSH_IMM:  push_o = imm_val;
      default:   push_o = result_i;
    endcase
    is_cont_o = (kind == PUSH_CONT);
  end
endmodule

// File: rtl/rq_shift_queue.sv
module rq_shift_queue #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push_en_i,
  input  logic [DATA_W-1:0]       push_i,
  input  logic                    q_next_i,
  output logic [DEPTH*DATA_W-1:0] flat_o,
  output logic [DATA_W-1:0]       s0_o,
  output logic                    q_o
);
  logic [DATA_W-1:0] stage [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)            stage[0] <= '0;
        else if (push_en_i) stage[0] <= push_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)            stage[g] <= '0;
        else if (push_en_i) stage[g] <= stage[g-1];
      end
    end
    assign flat_o[g*DATA_W +: DATA_W] = stage[g];
  end

  always_ff @(posedge clk) begin
    if (rst)            q_o <= 1'b0;
    else if (push_en_i) q_o <= q_next_i;
  end

  assign s0_o = stage[0];

  // R1: queue and flag come out of reset empty
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stage[0] == '0 && stage[DEPTH-1] == '0 && !q_o));
  // R2: older entry moves one slot deeper on retire
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    push_en_i |=> (stage[1] == $past(stage[0])));
  // R3: no retire, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !push_en_i |=> ($stable(stage[0]) && $stable(stage[DEPTH-1]) && $stable(q_o)));
endmodule

// File: rtl/rq_unary_op.sv
module rq_unary_op #(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        sel_i,
  input  logic              q_i,
  input  logic [DATA_W-1:0] s0_i,
  input  logic [DATA_W-1:0] here_i,
  input  logic [DATA_W-1:0] mask_imm_i,
  input  logic [DATA_W-1:0] perf_cyc_i,
  input  logic [DATA_W-1:0] perf_ret_i,
  input  logic [DATA_W-1:0] perf_ns_i,
  input  logic [DATA_W-1:0] perf_rnd_i,
  output logic [DATA_W-1:0] fr_o,
  output logic              fr_mem_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
  logic [DATA_W-1:0] even_s0, perf_val;

  always_comb begin
    even_s0 = s0_i[0] ? ~s0_i : s0_i;
    unique case (s0_i[1:0])
      2'd0:    perf_val = perf_cyc_i;
      2'd1:    perf_val = perf_ret_i;
      2'd2:    perf_val = perf_ns_i;
      default: perf_val = perf_rnd_i;
    endcase
    fr_mem_o = 1'b0;
    if (!q_i) begin
      unique case (sel_i)
        3'd5:    fr_o = s0_i & ONE;
        3'd6:    fr_o = s0_i + ONE;
        3'd7:    fr_o = ~s0_i;
        default: fr_o = {{(DATA_W-3){1'b0}}, sel_i};
      endcase
    end else begin
      unique case (sel_i)
        3'd0: fr_o = mask_imm_i;
        3'd1: fr_o = s0_i << 8;
        3'd2: fr_o = s0_i << 16;
        3'd3: fr_o = s0_i << 24;
        3'd4: fr_o = here_i + even_s0;
        3'd5: begin fr_o = '0; fr_mem_o = 1'b1; end
        3'd6: fr_o = perf_val;
        default: fr_o = ~s0_i;
      endcase
    end
  end

  // R11: a memory request never carries a data value of its own
  always_comb begin
    if (fr_mem_o) p_mem_zero_r11: assert (fr_o == '0);
  end
endmodule

// File: rtl/result_queue_core.sv
module result_queue_core
  import rq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    retire_i,
  input  logic [15:0]             instr_i,
  input  logic [DATA_W-1:0]       result_i,
  input  logic [DATA_W-1:0]       here_i,
  input  logic [DATA_W-1:0]       mask_imm_i,
  input  logic [DATA_W-1:0]       perf_cyc_i,
  input  logic [DATA_W-1:0]       perf_ret_i,
  input  logic [DATA_W-1:0]       perf_ns_i,
  input  logic [DATA_W-1:0]       perf_rnd_i,
  input  logic [2:0]              fr_sel_i,
  output logic [DEPTH*DATA_W-1:0] sq_o,
  output logic                    q_o,
  output logic [DATA_W-1:0]       fr_o,
  output logic                    fr_mem_o
);
  logic [DATA_W-1:0] s0, push_val;
  logic              is_cont;

  rq_push_mux #(.DATA_W(DATA_W)) push_i (
    .instr_i  (instr_i),
    .s0_i     (s0),
    .q_i      (q_o),
    .result_i (result_i),
    .push_o   (push_val),
    .is_cont_o(is_cont)
  );

  rq_shift_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) queue_i (
    .clk      (clk),
    .rst      (rst),
    .push_en_i(retire_i),
    .push_i   (push_val),
    .q_next_i (is_cont),
    .flat_o   (sq_o),
    .s0_o     (s0),
    .q_o      (q_o)
  );

  rq_unary_op #(.DATA_W(DATA_W)) unary_i (
    .sel_i     (fr_sel_i),
    .q_i       (q_o),
    .s0_i      (s0),
    .here_i    (here_i),
    .mask_imm_i(mask_imm_i),
    .perf_cyc_i(perf_cyc_i),
    .perf_ret_i(perf_ret_i),
    .perf_ns_i (perf_ns_i),
    .perf_rnd_i(perf_rnd_i),
    .fr_o      (fr_o),
    .fr_mem_o  (fr_mem_o)
  );

  // R4: an unchained prefix lands zero-extended in slot 0
  p_cont_r4: assert property (@(posedge clk) disable iff (rst)
    (retire_i && instr_i[15:13] == 3'b110 && !q_o)
      |=> (s0 == {{(DATA_W-CONT_BITS){1'b0}}, $past(instr_i[CONT_BITS-1:0])}));
  // R5: flag follows the kind of the last retired instruction
  p_qset_r5: assert property (@(posedge clk) disable iff (rst)
    (retire_i && instr_i[15:13] == 3'b110) |=> q_o);
  p_qclr_r5: assert property (@(posedge clk) disable iff (rst)
    (retire_i && instr_i[15:13] != 3'b110) |=> !q_o);
endmodule

// File: tb/result_queue_core_tb.sv
`timescale 1ns/1ps
module result_queue_core_tb_top;
  localparam real CLK_PERIOD = 10.0;
  localparam int  W = 64;
  localparam int  D = 8;

  logic clk = 1'b0, rst = 1'b1, retire = 1'b0;
  logic [15:0] instr = '0;
  logic [W-1:0] result = '0, here = 64'h0000_0000_0040_1000;
  logic [W-1:0] mask_imm = 64'hA5A5_0F0F_3C3C_9669;
  logic [W-1:0] pc_cyc = 64'h1111_0000_0000_0001, pc_ret = 64'h2222_0000_0000_0002;
  logic [W-1:0] pc_ns = 64'h3333_0000_0000_0003, pc_rnd = 64'h4444_0000_0000_0004;
  logic [2:0] sel = '0;
  logic [D*W-1:0] sq;
  logic q, fr_mem;
  logic [W-1:0] fr;

  int vectors = 0, fails = 0;
  logic [W-1:0] m_s [D];
  logic m_q;

  result_queue_core #(.DATA_W(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .retire_i(retire), .instr_i(instr), .result_i(result),
    .here_i(here), .mask_imm_i(mask_imm), .perf_cyc_i(pc_cyc), .perf_ret_i(pc_ret),
    .perf_ns_i(pc_ns), .perf_rnd_i(pc_rnd), .fr_sel_i(sel), .sq_o(sq), .q_o(q),
    .fr_o(fr), .fr_mem_o(fr_mem));

  always #(CLK_PERIOD/2.0) clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_fr(input logic [2:0] s, input logic qq,
                                          input logic [W-1:0] v);
    if (!qq) begin
      if (s <= 3'd4) return W'(s);
      if (s == 3'd5) return v & 64'd1;
      if (s == 3'd6) return v + 64'd1;
      return ~v;
    end
    case (s)
      3'd0: return mask_imm;
      3'd1: return v * 64'd256;
      3'd2: return v * 64'd65536;
      3'd3: return v * 64'd16777216;
      3'd4: return here + ((v % 2 == 0) ? v : ~v);
      3'd5: return 64'd0;
      3'd6: case (v % 4)
              0: return pc_cyc;
              1: return pc_ret;
              2: return pc_ns;
              default: return pc_rnd;
            endcase
      default: return ~v;
    endcase
  endfunction

  task automatic check_all(input string req);
    for (int k = 0; k < D; k++) chk(req, sq[k*W +: W], m_s[k]);
    chk({req, " flag R5"}, {63'd0, q}, {63'd0, m_q});
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      #0.4;
      if (!m_q) chk("R7 fr", fr, exp_fr(3'(s), m_q, m_s[0]));
      else if (s == 4) chk("R9 fr", fr, exp_fr(3'(s), m_q, m_s[0]));
      else if (s == 6) chk("R10 fr", fr, exp_fr(3'(s), m_q, m_s[0]));
      else if (s == 5) chk("R11 fr", fr, 64'd0);
      else chk("R8 fr", fr, exp_fr(3'(s), m_q, m_s[0]));
      chk("R11 mem", {63'd0, fr_mem}, {63'd0, (m_q && s == 5)});
    end
  endtask

  task automatic step(input logic ret, input logic [15:0] ins,
                      input logic [W-1:0] res, input string req);
    logic [W-1:0] pv;
    retire = ret; instr = ins; result = res;
    @(posedge clk);
    if (ret) begin
      if (ins[15:13] == 3'b110)
        pv = {51'd0, ins[12:0]} | (m_q ? m_s[0] * 64'd8192 : 64'd0);
      else if (ins[15:11] == 5'b11110)
        pv = {53'd0, ins[10:0]} | (m_q ? m_s[0] * 64'd2048 : 64'd0);
      else pv = res;
      for (int k = D-1; k > 0; k--) m_s[k] = m_s[k-1];
      m_s[0] = pv;
      m_q = (ins[15:13] == 3'b110);
    end
    @(negedge clk);
    retire = 1'b0;
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 30000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < D; k++) m_s[k] = '0;
    m_q = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check_all("R1 reset");
    // R2: plain results shift through every slot
    for (int i = 0; i < 10; i++)
      step(1'b1, 16'h0123, 64'hFFFF_FFFF_FFFF_FFF0 + 64'(i) * 64'h0101, "R2 push");
    step(1'b1, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, "R2 ones");
    // R3: idle cycles ignore instruction and result
    step(1'b0, 16'hC123, 64'hDEAD, "R3 hold");
    step(1'b0, 16'hF7FF, 64'hBEEF, "R3 hold");
    // R4/R6: single and chained prefixes, immediates
    step(1'b1, 16'hDABC, 64'h0, "R4 cont");
    step(1'b0, 16'h0000, 64'h5, "R3 hold q");
    step(1'b1, 16'hC001, 64'h0, "R4 chain");
    step(1'b1, 16'hF7FF, 64'h0, "R6 imm chained");
    step(1'b1, 16'hF432, 64'h0, "R6 imm plain");
    step(1'b1, 16'hDFFF, 64'h0, "R4 cont");
    step(1'b1, 16'hDFFF, 64'h0, "R4 chain");
    step(1'b1, 16'hDFFF, 64'h0, "R4 chain");
    step(1'b1, 16'h1234, 64'h77, "R5 clear");
    // sweep prefix fields: even/odd and all counter codes (R9, R10)
    for (int i = 0; i < 96; i++) begin
      step(1'b1, 16'hC000 | 16'((i * 613) % 8192), 64'h0, "R4 sweep");
      if (i % 3 == 0) step(1'b1, 16'hC000 | 16'(i), 64'h0, "R4 sweep chain");
      step(1'b1, 16'hF000 | 16'(i * 7), 64'h0, "R6 sweep");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule